// File: doc/BRIEF.md
# Clock-Multiplier Control Register Block

This block is the software-facing control plane of a phase-locked-loop clock multiplier. It sits on an 8-bit peripheral bus and keeps three byte registers: a run/select register, a loop-bandwidth register and a frequency-setting register. Their fields drive the analog loop, the clock switch and the interrupt controller. The block also takes the loop's lock and tracking indications back in, so that software can poll them.

The block enforces several interlocks. Some bits are pinned to a value, and some refuse writes, depending on other bits. Automatic bandwidth mode gates the interrupt enable and the lock status. Selecting the multiplied clock as the base clock requires the loop to be running with a non-zero range. A running loop cannot be retuned.

A small two-state machine remembers the last level of the lock input. Its states are `LK_LOW` and `LK_HIGH`. It moves from `LK_LOW` to `LK_HIGH` when the lock input rises, and from `LK_HIGH` to `LK_LOW` when it falls. Every transition raises a one-cycle edge pulse, which sets the lock-change flag while automatic mode is on. Software clears the flag by reading the run/select register.

Top module: `clkgen_ctl_regs`

## Requirements
- R1: After reset, the three registers sit at BASE_ADDR+0 (run/select), BASE_ADDR+1 (bandwidth) and BASE_ADDR+2 (frequency), with BASE_ADDR defaulting to 0x1C. They read 0x2F, 0x00 and 0x66. Any other address reads 0x00.
- R2: The run/select register has bit 7 = interrupt enable, bit 6 = lock-change flag (read only), bit 5 = loop run and bit 4 = base clock select. Bits 3:0 always read 1 and ignore writes.
- R3: The bandwidth register has bit 7 = automatic mode, bit 6 = lock status (read only), bit 5 = tracking select/status (1 = tracking, 0 = acquisition) and bit 4 = crystal-loss detect request. Bits 3:0 always read 0 and ignore writes.
- R4: The frequency register holds the multiplier in bits 7:4 and the range in bits 3:0. Writes to it are ignored while loop run is 1.
- R5: While automatic mode is 0, the interrupt enable ignores writes and is held at 0, and the lock-change flag and the lock status bit read 0. An enable set earlier does not survive a return to automatic mode.
- R6: While automatic mode is 1, bit 5 of the bandwidth register ignores writes and reads the tracking input. While automatic mode is 0, bit 5 is writable, reads back the stored value and drives the manual tracking select output.
- R7: Base clock select takes a written 1 only if the range field is non-zero and loop run is 1. Loop run here is its value after the same write.
- R8: While base clock select is 1, loop run stays 1 on any write. A single write of 0x00 clears base clock select but leaves loop run at 1.
- R9: While automatic mode is 1, the lock-change flag is set one clock after a rising or falling lock input. A read of the run/select register clears it. A set in the same cycle as that read wins.
- R10: The interrupt request equals interrupt enable AND lock-change flag, and is 0 whenever automatic mode is 0.
- R11: The output ports always show the stored loop run, base select, multiplier, range, automatic mode, manual tracking select and crystal-loss request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe (clears the lock-change flag on the run/select register) |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| pll_locked_i | input | 1 | Lock indication from the loop |
| pll_track_i | input | 1 | 1 while the loop is in tracking, 0 in acquisition |
| pll_en_o | output | 1 | Loop run |
| base_sel_o | output | 1 | Base clock select (multiplied clock) |
| mult_o | output | 4 | Multiplier field |
| vrange_o | output | 4 | Range field |
| auto_o | output | 1 | Automatic bandwidth mode |
| acq_sel_o | output | 1 | Manual tracking select (1 = tracking) |
| xtal_chk_o | output | 1 | Crystal-loss detect request |
| irq_o | output | 1 | Lock-change interrupt request |

## Verification
The embedded assertions check the invariants on every cycle:
- Base select never stands without a running loop and a non-zero range.
- Base select keeps the loop running into the next cycle.
- The frequency field and the stored tracking bit hold through writes that are locked out.
- Leaving automatic mode clears the interrupt enable and the flag.
- Every lock edge under automatic mode sets the flag, and every rising lock level produces an edge.

Only the bench scenarios show the rest: the exact read-back values with their padding bits, the same-write ordering of run and base select, the one-cycle latency from lock edge to interrupt, and the clear-by-read race.

// File: rtl/clkgen_ctl_pkg.sv
package clkgen_ctl_pkg;

    localparam int REG_W  = 8;
    localparam int NIB_W  = 4;

    localparam int CTRL_OFS = 0;
    localparam int BW_OFS   = 1;
    localparam int PROG_OFS = 2;

    localparam logic [NIB_W-1:0] MULT_RST   = 4'h6;
    localparam logic [NIB_W-1:0] VRANGE_RST = 4'h6;
    localparam logic             RUN_RST    = 1'b1;

    localparam logic [NIB_W-1:0] CTRL_PAD = {NIB_W{1'b1}};
    localparam logic [NIB_W-1:0] BW_PAD   = {NIB_W{1'b0}};

    typedef enum logic {
        LK_LOW  = 1'b0,
        LK_HIGH = 1'b1
    } lock_state_e;

endpackage

// File: rtl/clkgen_lock_track.sv
module clkgen_lock_track
    import clkgen_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lock_i,
    output logic edge_o
);

    lock_state_e state_q;
    lock_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LK_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        edge_o  = 1'b0;
        unique case (state_q)
            LK_LOW: begin
                if (lock_i) begin
                    state_d = LK_HIGH;
                    edge_o  = 1'b1;
                end
            end
            LK_HIGH: begin
                if (!lock_i) begin
                    state_d = LK_LOW;
                    edge_o  = 1'b1;
                end
            end
            default: begin
                state_d = LK_LOW;
            end
        endcase
    end

    // R9: a rising lock level always yields an edge pulse
    a_r9_rise_gives_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_i) |-> edge_o);

endmodule

// File: rtl/clkgen_ctrl_reg.sv
module clkgen_ctrl_reg
    import clkgen_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic rd_clr,
    input  logic wr_ie,
    input  logic wr_run,
    input  logic wr_base,
    input  logic auto_i,
    input  logic vrange_nz_i,
    input  logic lock_edge_i,
    output logic irq_en_o,
    output logic flag_o,
    output logic run_o,
    output logic base_o
);

    logic irq_en_q, flag_q, run_q, base_q;
    logic run_eff, base_eff;

    // base select holds run high; base itself needs the post-write run
    assign run_eff  = wr_run | base_q;
    assign base_eff = wr_base & run_eff & vrange_nz_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en_q <= 1'b0;
            run_q    <= RUN_RST;
            base_q   <= 1'b0;
        end else begin
            if (!auto_i) begin
                irq_en_q <= 1'b0;
            end else if (wr_en) begin
                irq_en_q <= wr_ie;
            end
            if (wr_en) begin
                run_q  <= run_eff;
                base_q <= base_eff;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (!auto_i) begin
            flag_q <= 1'b0;
        end else if (lock_edge_i) begin
            flag_q <= 1'b1;
        end else if (rd_clr) begin
            flag_q <= 1'b0;
        end
    end

    assign irq_en_o = irq_en_q;
    assign flag_o   = flag_q;
    assign run_o    = run_q;
    assign base_o   = base_q;

    // R7: base select only with a running loop and a non-zero range
    a_r7_base_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        base_q |-> (run_q && vrange_nz_i));

    // R8: base select keeps the loop running into the next cycle
    a_r8_run_held: assert property (@(posedge clk) disable iff (!rst_n)
        base_q |=> run_q);

    // R5: leaving automatic mode clears enable and flag
    a_r5_manual_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_i |=> (!irq_en_q && !flag_q));

    // R9: a lock edge under automatic mode sets the flag
    a_r9_edge_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_i && lock_edge_i) |=> flag_q);

endmodule

// File: rtl/clkgen_bw_reg.sv
module clkgen_bw_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_auto,
    input  logic wr_acq,
    input  logic wr_xtal,
    output logic auto_o,
    output logic acq_o,
    output logic xtal_o
);

    logic auto_q, acq_q, xtal_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            auto_q <= 1'b0;
            acq_q  <= 1'b0;
            xtal_q <= 1'b0;
        end else if (wr_en) begin
            auto_q <= wr_auto;
            xtal_q <= wr_xtal;
            if (!auto_q) begin
                acq_q <= wr_acq;
            end
        end
    end

    assign auto_o = auto_q;
    assign acq_o  = acq_q;
    assign xtal_o = xtal_q;

    // R6: stored tracking select holds through writes in automatic mode
    a_r6_acq_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && auto_q) |=> $stable(acq_q));

endmodule

// File: rtl/clkgen_prog_reg.sv
module clkgen_prog_reg
    import clkgen_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             run_i,
    input  logic [REG_W-1:0] wdata,
    output logic [NIB_W-1:0] mult_o,
    output logic [NIB_W-1:0] vrange_o
);

    logic [NIB_W-1:0] mult_q, vrange_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mult_q   <= MULT_RST;
            vrange_q <= VRANGE_RST;
        end else if (wr_en && !run_i) begin
            mult_q   <= wdata[REG_W-1:NIB_W];
            vrange_q <= wdata[NIB_W-1:0];
        end
    end

    assign mult_o   = mult_q;
    assign vrange_o = vrange_q;

    // R4: a running loop cannot be retuned
    a_r4_prog_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && run_i) |=> ($stable(mult_q) && $stable(vrange_q)));

endmodule

// File: rtl/clkgen_ctl_regs.sv
module clkgen_ctl_regs
    import clkgen_ctl_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h1C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic              bus_rd,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              pll_locked_i,
    input  logic              pll_track_i,
    output logic              pll_en_o,
    output logic              base_sel_o,
    output logic [NIB_W-1:0]  mult_o,
    output logic [NIB_W-1:0]  vrange_o,
    output logic              auto_o,
    output logic              acq_sel_o,
    output logic              xtal_chk_o,
    output logic              irq_o
);

    localparam logic [ADDR_W-1:0] CTRL_ADDR = BASE_ADDR + ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] BW_ADDR   = BASE_ADDR + ADDR_W'(BW_OFS);
    localparam logic [ADDR_W-1:0] PROG_ADDR = BASE_ADDR + ADDR_W'(PROG_OFS);

    logic sel_ctrl, sel_bw, sel_prog;
    logic lock_edge;
    logic irq_en, flag, run, base, auto_m, acq_st, xtal;
    logic [NIB_W-1:0] mult, vrange;
    logic [REG_W-1:0] ctrl_byte, bw_byte, prog_byte;

    assign sel_ctrl = (bus_addr == CTRL_ADDR);
    assign sel_bw   = (bus_addr == BW_ADDR);
    assign sel_prog = (bus_addr == PROG_ADDR);

    clkgen_lock_track u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .lock_i (pll_locked_i),
        .edge_o (lock_edge)
    );

    clkgen_ctrl_reg u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (bus_wr && sel_ctrl),
        .rd_clr      (bus_rd && sel_ctrl),
        .wr_ie       (bus_wdata[7]),
        .wr_run      (bus_wdata[5]),
        .wr_base     (bus_wdata[4]),
        .auto_i      (auto_m),
        .vrange_nz_i (vrange != '0),
        .lock_edge_i (lock_edge),
        .irq_en_o    (irq_en),
        .flag_o      (flag),
        .run_o       (run),
        .base_o      (base)
    );

    clkgen_bw_reg u_bw (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr && sel_bw),
        .wr_auto (bus_wdata[7]),
        .wr_acq  (bus_wdata[5]),
        .wr_xtal (bus_wdata[4]),
        .auto_o  (auto_m),
        .acq_o   (acq_st),
        .xtal_o  (xtal)
    );

    clkgen_prog_reg u_prog (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr && sel_prog),
        .run_i    (run),
        .wdata    (bus_wdata),
        .mult_o   (mult),
        .vrange_o (vrange)
    );

    // bit 6 of the bandwidth register is a status read; writes to it are dropped
    logic unused_wbit6;
    assign unused_wbit6 = bus_wdata[6];

    always_comb begin
        ctrl_byte = {irq_en & auto_m, flag & auto_m, run, base, CTRL_PAD};
        bw_byte   = {auto_m, pll_locked_i & auto_m,
                     auto_m ? pll_track_i : acq_st, xtal, BW_PAD};
        prog_byte = {mult, vrange};
        if (sel_ctrl) begin
            bus_rdata = ctrl_byte;
        end else if (sel_bw) begin
            bus_rdata = bw_byte;
        end else if (sel_prog) begin
            bus_rdata = prog_byte;
        end else begin
            bus_rdata = '0;
        end
    end

    assign pll_en_o   = run;
    assign base_sel_o = base;
    assign mult_o     = mult;
    assign vrange_o   = vrange;
    assign auto_o     = auto_m;
    assign acq_sel_o  = acq_st;
    assign xtal_chk_o = xtal;
    assign irq_o      = irq_en & flag & auto_m;

    // R10: interrupt request implies automatic mode is on
    a_r10_irq_needs_auto: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> auto_o);

endmodule

// File: tb/clkgen_ctl_regs_bench.sv
module clkgen_ctl_regs_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_CTRL = 8'h1C;
    localparam logic [7:0] A_BW   = 8'h1D;
    localparam logic [7:0] A_PROG = 8'h1E;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       pll_locked_i = 1'b0;
    logic       pll_track_i = 1'b0;
    logic       pll_en_o, base_sel_o, auto_o, acq_sel_o, xtal_chk_o, irq_o;
    logic [3:0] mult_o, vrange_o;

    int n_checks = 0;
    int n_errors = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    clkgen_ctl_regs u_clkgen_ctl_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_wr       (bus_wr),
        .bus_wdata    (bus_wdata),
        .bus_rd       (bus_rd),
        .bus_rdata    (bus_rdata),
        .pll_locked_i (pll_locked_i),
        .pll_track_i  (pll_track_i),
        .pll_en_o     (pll_en_o),
        .base_sel_o   (base_sel_o),
        .mult_o       (mult_o),
        .vrange_o     (vrange_o),
        .auto_o       (auto_o),
        .acq_sel_o    (acq_sel_o),
        .xtal_chk_o   (xtal_chk_o),
        .irq_o        (irq_o)
    );

    // monitor: compares each read against the scoreboard head
    always begin
        sb_item_t it;
        @(negedge clk);
        #(CLK_PERIOD/4);
        if (bus_rd) begin
            n_checks++;
            if (sb_q.size() == 0) begin
                n_errors++;
                $display("FAIL read with empty scoreboard: actual=%h expected=none", bus_rdata);
            end else begin
                it = sb_q.pop_front();
                if (bus_rdata !== it.exp) begin
                    n_errors++;
                    $display("FAIL %s: actual=%h expected=%h", it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [7:0] e,
                            input string tag, input bit flip_lock);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        if (flip_lock) pll_locked_i = ~pll_locked_i;
        sb_q.push_back('{exp: e, tag: tag});
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values and map
        bus_read(A_CTRL, 8'h2F, "R1 ctrl reset", 0);
        bus_read(A_BW,   8'h00, "R1 bw reset", 0);
        bus_read(A_PROG, 8'h66, "R1 prog reset", 0);
        bus_read(8'h1F,  8'h00, "R1 unmapped", 0);
        chk("R11 run out", {7'd0, pll_en_o}, 8'h01);
        chk("R11 mult/range out", {mult_o, vrange_o}, 8'h66);
        chk("R10 irq reset", {7'd0, irq_o}, 8'h00);

        // R4 locked while running
        bus_write(A_PROG, 8'h3A);
        bus_read(A_PROG, 8'h66, "R4 locked write", 0);
        // R2 padding and run clear
        bus_write(A_CTRL, 8'h00);
        bus_read(A_CTRL, 8'h0F, "R2 pad ones", 0);
        bus_write(A_PROG, 8'h3A);
        bus_read(A_PROG, 8'h3A, "R4 open write", 0);
        chk("R11 mult/range out", {mult_o, vrange_o}, 8'h3A);

        // R7 base select gating
        bus_write(A_CTRL, 8'h10);
        bus_read(A_CTRL, 8'h0F, "R7 base without run", 0);
        bus_write(A_PROG, 8'h30);
        bus_write(A_CTRL, 8'h30);
        bus_read(A_CTRL, 8'h2F, "R7 base with zero range", 0);
        bus_write(A_CTRL, 8'h00);
        bus_write(A_PROG, 8'h3A);
        bus_write(A_CTRL, 8'h30);
        bus_read(A_CTRL, 8'h3F, "R7 same-write run and base", 0);
        chk("R11 base out", {7'd0, base_sel_o}, 8'h01);

        // R8 run held by base
        bus_write(A_CTRL, 8'h10);
        bus_read(A_CTRL, 8'h3F, "R8 run held", 0);
        bus_write(A_CTRL, 8'h00);
        bus_read(A_CTRL, 8'h2F, "R8 base clears, run stays", 0);
        bus_write(A_CTRL, 8'h00);
        bus_read(A_CTRL, 8'h0F, "R8 run clears afterwards", 0);

        // R5 / R3 manual mode
        bus_write(A_CTRL, 8'h80);
        bus_read(A_CTRL, 8'h0F, "R5 enable ignored", 0);
        @(negedge clk);
        pll_locked_i = 1'b1;
        pll_track_i  = 1'b1;
        bus_read(A_BW, 8'h00, "R5 lock hidden", 0);
        bus_read(A_CTRL, 8'h0F, "R5 flag hidden", 0);
        bus_write(A_BW, 8'h3F);
        bus_read(A_BW, 8'h30, "R3 manual layout", 0);
        chk("R6 manual select out", {6'd0, acq_sel_o, xtal_chk_o}, 8'h03);

        // R6 automatic mode
        bus_write(A_BW, 8'h80);
        bus_read(A_BW, 8'hE0, "R6 auto reflects input", 0);
        bus_write(A_BW, 8'hA0);
        @(negedge clk);
        pll_track_i = 1'b0;
        bus_read(A_BW, 8'hC0, "R6 auto write ignored", 0);
        chk("R6 stored select", {7'd0, acq_sel_o}, 8'h00);
        chk("R11 auto out", {7'd0, auto_o}, 8'h01);
        bus_read(A_CTRL, 8'h0F, "R9 no flag from manual-mode edge", 0);

        // R9 / R10 lock events
        bus_write(A_CTRL, 8'h80);
        bus_read(A_CTRL, 8'h8F, "R5 enable in auto", 0);
        @(negedge clk);
        pll_locked_i = 1'b0;
        @(negedge clk);
        chk("R10 irq after fall", {7'd0, irq_o}, 8'h01);
        bus_read(A_CTRL, 8'hCF, "R9 flag on fall", 0);
        bus_read(A_CTRL, 8'h8F, "R9 read clears", 0);
        chk("R10 irq cleared", {7'd0, irq_o}, 8'h00);
        @(negedge clk);
        pll_locked_i = 1'b1;
        @(negedge clk);
        bus_read(A_BW, 8'hC0, "R3 lock status", 0);
        bus_read(A_CTRL, 8'hCF, "R9 flag on rise", 0);
        bus_read(A_CTRL, 8'h8F, "R9 set-wins read", 1);
        bus_read(A_CTRL, 8'hCF, "R9 set wins", 0);
        bus_read(A_CTRL, 8'h8F, "R9 cleared", 0);

        // R5 return to manual clears enable
        bus_write(A_BW, 8'h00);
        chk("R10 irq off in manual", {7'd0, irq_o}, 8'h00);
        @(negedge clk);
        pll_locked_i = 1'b0;
        @(negedge clk);
        bus_write(A_BW, 8'h80);
        bus_read(A_CTRL, 8'h0F, "R5 enable lost", 0);
        chk("R10 irq stays low", {7'd0, irq_o}, 8'h00);

        repeat (2) @(negedge clk);
        if (sb_q.size() != 0) begin
            n_checks++;
            n_errors++;
            $display("FAIL scoreboard leftover: actual=%0d expected=0", sb_q.size());
        end
        summary();
        $finish;
    end

endmodule